// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block owns the fetch address of a processor with fixed 32-bit, word-aligned instructions. On every enabled clock edge it moves the program counter to one of three places. By default it steps to the next instruction. A conditional branch that is taken moves it by a signed count of instructions measured from the instruction that follows the branch. A jump moves it to an address inside the current 256 MB region, built from the instruction's 26-bit target field.

The fetched instruction and an equality flag arrive at the inputs in the same cycle. The flag comes from comparing the two register operands elsewhere. The unit works out the next address combinationally and registers it. It also presents the current address plus four, which a return-address write path can use. A separate strobe marks the cycles in which that value should be written as a link. When the advance enable is low, the address is frozen.

Top module: `pc_sequencer`

## Requirements
- R1: When an instruction with opcode (bits 31:26) 4 or 5 is not taken, the next PC is the current PC plus 4.
- R2: Opcode 4 with `operands_equal` high sets the next PC to (PC+4) + sign-extended bits 15:0 shifted left by two.
- R3: Opcode 5 with `operands_equal` low sets the next PC with the same offset arithmetic as R2. Opcode 5 with `operands_equal` high advances by 4.
- R4: The 16-bit branch offset is two's complement. 0x8000 moves the PC back 32768 instructions from PC+4, and 0x7FFF moves it forward 32767 instructions.
- R5: Opcodes 2 and 3 set the next PC to {PC+4 bits 31:28, instruction bits 25:0, 2'b00}.
- R6: The upper four bits of a jump target come from PC+4 and not from PC. This matters when PC is the last word of a 256 MB region.
- R7: Opcode 0, and any opcode other than 2, 3, 4 and 5, advances the PC by 4 whatever the value of `operands_equal`.
- R8: A low `rst_n` at a rising clock edge loads `RESET_VEC` (default 0x00400000). This takes priority over every other input. `pc_now` bits 1:0 are always zero.
- R9: While `advance_en` is low, the PC keeps its value even when a branch is taken or a jump is presented.
- R10: `pc_plus4` always equals `pc_now` + 4. `link_valid` is high exactly when the opcode is 3 and `advance_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| advance_en | input | 1 | Allows the PC to update on this edge |
| instr_word | input | 32 | Instruction fetched at `pc_now` |
| operands_equal | input | 1 | High when the two compared register operands are equal |
| pc_now | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Current program counter plus 4 (return address) |
| link_valid | output | 1 | High when `pc_plus4` should be written as a link |

## Verification
Two events can fall in the same cycle: a stall and a redirect. The bench presents a taken-looking jump, and a jump-and-link, while `advance_en` is low. It then checks that `pc_now` has not moved after the edge and that `link_valid` stayed low before it. A reset also meets a redirect in one cycle. The bench holds `rst_n` low while a jump is presented with the enable high, and checks that the reset vector wins. A second instance starts at the last word of a region, so a jump there shows whether the region bits come from PC+4.

// File: rtl/pcseq_pkg.sv
// Package: shared field positions, opcode codes and the next-address select type.
// Assumes a fixed 32-bit instruction word with a 6-bit opcode in the top bits.
package pcseq_pkg;

    localparam int XLEN     = 32;
    localparam int OPC_W    = 6;
    localparam int OPC_LSB  = XLEN - OPC_W;
    localparam int IMM_W    = 16;
    localparam int TGT_W    = XLEN - OPC_W;
    localparam int ALIGN_W  = 2;
    localparam int REGION_W = XLEN - TGT_W - ALIGN_W;
    localparam int SEXT_W   = XLEN - IMM_W - ALIGN_W;

    localparam logic [OPC_W-1:0] OPC_JUMP   = 6'd2;
    localparam logic [OPC_W-1:0] OPC_JLINK  = 6'd3;
    localparam logic [OPC_W-1:0] OPC_BR_EQ  = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BR_NE  = 6'd5;

    typedef enum logic [1:0] {
        NX_SEQ    = 2'd0,
        NX_BRANCH = 2'd1,
        NX_JUMP   = 2'd2
    } nx_sel_e;

endpackage

// File: rtl/pcseq_decode.sv
// Module: picks the next-address source from the opcode and the equality flag.
// Assumes the opcode belongs to the instruction fetched at the current PC.
module pcseq_decode
    import pcseq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    input  logic             operands_equal,
    output nx_sel_e          nx_sel,
    output logic             is_link
);

    // Source select: branches depend on the flag, jumps always redirect, the rest advance.
    always_comb begin
        nx_sel  = NX_SEQ;
        is_link = 1'b0;
        case (opcode)
            OPC_BR_EQ: nx_sel = operands_equal ? NX_BRANCH : NX_SEQ;
            OPC_BR_NE: nx_sel = operands_equal ? NX_SEQ : NX_BRANCH;
            OPC_JUMP:  nx_sel = NX_JUMP;
            OPC_JLINK: begin
                nx_sel  = NX_JUMP;
                is_link = 1'b1;
            end
            default:   nx_sel = NX_SEQ;
        endcase
    end

    // R3: opcode 5 with equal operands must never select the branch target
    always_comb begin
        if (opcode == OPC_BR_NE && operands_equal)
            a_bne_equal_r3: assert (nx_sel == NX_SEQ);
    end

endmodule

// File: rtl/pcseq_target.sv
// Module: forms the branch and jump targets from PC+4 and the instruction fields.
// Assumes PC+4 is word aligned; both targets therefore stay word aligned.
module pcseq_target
    import pcseq_pkg::*;
(
    input  logic [XLEN-1:0]  pc_plus4,
    input  logic [TGT_W-1:0] low_field,
    output logic [XLEN-1:0]  br_target,
    output logic [XLEN-1:0]  jmp_target
);

    logic [IMM_W-1:0] imm;
    logic [XLEN-1:0]  br_offset;

    // Offset: sign-extend the instruction count and scale it to bytes.
    always_comb begin
        imm       = low_field[IMM_W-1:0];
        br_offset = {{SEXT_W{imm[IMM_W-1]}}, imm, {ALIGN_W{1'b0}}};
        br_target = pc_plus4 + br_offset;
    end

    // Jump: keep the region bits of PC+4, insert the target field, append zero bits.
    always_comb begin
        jmp_target = {pc_plus4[XLEN-1 -: REGION_W], low_field, {ALIGN_W{1'b0}}};
    end

    // R5: both targets keep word alignment whenever PC+4 is aligned
    always_comb begin
        if (pc_plus4[ALIGN_W-1:0] == '0)
            a_tgt_align_r5: assert (br_target[ALIGN_W-1:0] == '0 && jmp_target[ALIGN_W-1:0] == '0);
    end

endmodule

// File: rtl/pcseq_reg.sv
// Module: the program counter register with synchronous active-low reset and hold.
// Assumes RESET_VEC is word aligned.
module pcseq_reg
    import pcseq_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en,
    input  logic [XLEN-1:0] pc_next,
    output logic [XLEN-1:0] pc_q
);

    // State: reset vector on reset, new address when enabled, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc_q <= RESET_VEC;
        else if (load_en)
            pc_q <= pc_next;
    end

    // R8: reset loads the vector on the following cycle
    p_reset_vec_r8: assert property (@(posedge clk) !rst_n |=> pc_q == RESET_VEC);

    // R9: no enable, no movement
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(pc_q));

endmodule

// File: rtl/pc_sequencer.sv
// Module: top of the next-address unit; decodes, forms targets, selects and registers.
// Assumes instr_word is the instruction at pc_now and operands_equal belongs to it.
module pc_sequencer
    import pcseq_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC = 32'h0040_0000
)(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance_en,
    input  logic [XLEN-1:0] instr_word,
    input  logic            operands_equal,
    output logic [XLEN-1:0] pc_now,
    output logic [XLEN-1:0] pc_plus4,
    output logic            link_valid
);

    localparam logic [XLEN-1:0] STEP = XLEN'(1 << ALIGN_W);

    nx_sel_e         nx_sel;
    logic            is_link;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] jmp_target;
    logic [XLEN-1:0] pc_next;

    pcseq_decode u_decode (
        .opcode         (instr_word[XLEN-1 -: OPC_W]),
        .operands_equal (operands_equal),
        .nx_sel         (nx_sel),
        .is_link        (is_link)
    );

    pcseq_target u_target (
        .pc_plus4   (pc_plus4),
        .low_field  (instr_word[TGT_W-1:0]),
        .br_target  (br_target),
        .jmp_target (jmp_target)
    );

    pcseq_reg #(.RESET_VEC(RESET_VEC)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (advance_en),
        .pc_next (pc_next),
        .pc_q    (pc_now)
    );

    // Sequential address and link strobe.
    always_comb begin
        pc_plus4   = pc_now + STEP;
        link_valid = is_link & advance_en;
    end

    // Next-address mux over the three sources.
    always_comb begin
        case (nx_sel)
            NX_BRANCH: pc_next = br_target;
            NX_JUMP:   pc_next = jmp_target;
            default:   pc_next = pc_plus4;
        endcase
    end

    // R8: the PC is always word aligned once out of reset
    p_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_now[ALIGN_W-1:0] == '0);

    // R1: a sequential choice steps by exactly one word
    p_seq_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_en && nx_sel == NX_SEQ) |=> pc_now == $past(pc_now) + 32'd4);

    // R2: taken branch-if-equal lands at PC+4 plus the scaled signed offset
    p_beq_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_en && instr_word[31:26] == 6'd4 && operands_equal)
        |=> pc_now == $past(pc_plus4)
            + {{14{$past(instr_word[15])}}, $past(instr_word[15:0]), 2'b00});

    // R6: a jump keeps the region bits of PC+4
    p_jump_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance_en && instr_word[31:27] == 5'b00001)
        |=> pc_now[31:28] == $past(pc_plus4[31:28]));

    // R10: no link strobe while stalled
    p_link_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_en |-> !link_valid);

endmodule

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [31:0] instr;
        logic        eq;
        logic        en;
        logic [31:0] exp_pc;
        logic        exp_link;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_1025, 1'b0, 1'b1, 32'h0040_0004, 1'b0, 8'd7},  // R7 register format
        '{32'h1100_0003, 1'b1, 1'b1, 32'h0040_0014, 1'b0, 8'd2},  // R2 beq taken +3
        '{32'h1100_0003, 1'b0, 1'b1, 32'h0040_0018, 1'b0, 8'd1},  // R1 beq not taken
        '{32'h1500_FFFE, 1'b0, 1'b1, 32'h0040_0014, 1'b0, 8'd3},  // R3 bne taken -2
        '{32'h1500_FFFE, 1'b1, 1'b1, 32'h0040_0018, 1'b0, 8'd3},  // R3 bne not taken
        '{32'h0810_0001, 1'b0, 1'b1, 32'h0040_0004, 1'b0, 8'd5},  // R5 jump
        '{32'h0C10_0040, 1'b0, 1'b1, 32'h0040_0100, 1'b1, 8'd10}, // R10 jump and link
        '{32'h0800_0000, 1'b1, 1'b0, 32'h0040_0100, 1'b0, 8'd9},  // R9 stalled jump
        '{32'h0C00_0000, 1'b0, 1'b0, 32'h0040_0100, 1'b0, 8'd9},  // R9 stalled link, no strobe
        '{32'h8D28_0000, 1'b1, 1'b1, 32'h0040_0104, 1'b0, 8'd7},  // R7 unknown opcode
        '{32'h1000_8000, 1'b1, 1'b1, 32'h003E_0108, 1'b0, 8'd4},  // R4 most negative offset
        '{32'h1000_7FFF, 1'b1, 1'b1, 32'h0040_0108, 1'b0, 8'd4},  // R4 most positive offset
        '{32'h0000_FFFF, 1'b1, 1'b1, 32'h0040_010C, 1'b0, 8'd7}   // R7 opcode 0 ignores flag
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        advance_en = 1'b0;
    logic [31:0] instr_word = 32'h0;
    logic        operands_equal = 1'b0;
    logic [31:0] pc_now, pc_plus4;
    logic        link_valid;

    logic        en_e = 1'b0;
    logic [31:0] instr_e = 32'h0;
    logic [31:0] pc_e, pc4_e;
    logic        link_e;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    pc_sequencer i_pc_sequencer (
        .clk(clk), .rst_n(rst_n), .advance_en(advance_en),
        .instr_word(instr_word), .operands_equal(operands_equal),
        .pc_now(pc_now), .pc_plus4(pc_plus4), .link_valid(link_valid)
    );

    pc_sequencer #(.RESET_VEC(32'h1FFF_FFFC)) i_pc_sequencer_edge (
        .clk(clk), .rst_n(rst_n), .advance_en(en_e),
        .instr_word(instr_e), .operands_equal(1'b0),
        .pc_now(pc_e), .pc_plus4(pc4_e), .link_valid(link_e)
    );

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 5000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] cur;
        repeat (2) @(negedge clk);
        check32("R8 reset vector", pc_now, 32'h0040_0000);
        check32("R10 pc_plus4 in reset", pc_plus4, 32'h0040_0004);
        check32("R8 edge reset vector", pc_e, 32'h1FFF_FFFC);
        rst_n = 1'b1;
        cur = 32'h0040_0000;

        for (int i = 0; i < NV; i++) begin
            instr_word     = VEC[i].instr;
            operands_equal = VEC[i].eq;
            advance_en     = VEC[i].en;
            #1;
            check32($sformatf("R10 pc_plus4 vec %0d", i), pc_plus4, cur + 32'd4);
            check32($sformatf("R%0d link vec %0d", VEC[i].req, i), {31'b0, link_valid}, {31'b0, VEC[i].exp_link});
            @(negedge clk);
            check32($sformatf("R%0d pc vec %0d", VEC[i].req, i), pc_now, VEC[i].exp_pc);
            cur = VEC[i].exp_pc;
        end

        // R6: region bits from PC+4 when PC is the last word of a region
        instr_e = 32'h0800_0010;
        en_e    = 1'b1;
        #1;
        check32("R6 edge pc_plus4", pc4_e, 32'h2000_0000);
        @(negedge clk);
        check32("R6 region from PC+4", pc_e, 32'h2000_0040);
        en_e = 1'b0;

        // R8: reset wins over a jump presented with the enable high
        advance_en = 1'b1;
        instr_word = 32'h0810_0040;
        rst_n      = 1'b0;
        @(negedge clk);
        check32("R8 reset over jump", pc_now, 32'h0040_0000);
        rst_n = 1'b1;
        @(negedge clk);
        check32("R5 jump after reset", pc_now, 32'h0040_0100);

        finish_run();
    end

endmodule